// File: doc/BRIEF.md
# Safety Fault Merge and PWM Break

This block turns several internal safety alarms into one emergency shutdown of a motor-drive output stage. The alarms are a RAM parity error, a supply-low event, a clock-failure event and a processor lockup. Each alarm can be masked by a per-source enable. The enabled alarms are merged, and the result is ORed with an external break pin. The output gating is purely combinational from the alarm inputs. A failing PWM stage is therefore silenced in the same cycle, with no wait for software or a clock edge.

A clocked latch remembers the break after the alarm clears, so the outputs stay at a programmable safe idle level until software re-arms. A re-arm only takes effect when no enabled alarm and no external break is still active. A cause register records the set of sources that were active on the edge where the break first latched. This lets the first fault be diagnosed even if later alarms follow.

Top module: `fault_break_unit`

## Requirements
- R1: An internal alarm whose enable bit is set forces pwm_o to the idle level in the same cycle, before any clock edge.
- R2: ext_brk_i forces pwm_o to the idle level in the same cycle, regardless of the enable bits.
- R3: An alarm whose enable bit is clear has no effect on pwm_o, brk_latched_o or cause_o.
- R4: While a break is active, live or latched, every bit of pwm_o equals the corresponding bit of the programmed idle level.
- R5: At the first rising edge where any enabled alarm or ext_brk_i is high, brk_latched_o goes high. It stays high after the alarm drops.
- R6: rearm_i clears brk_latched_o at the next edge only if no enabled alarm and no external break is active in that cycle. Otherwise the latch is held.
- R7: On the edge where the latch sets from clear, cause_o captures the live sources: bit 0 parity, bit 1 supply low, bit 2 clock failure, bit 3 lockup, bit 4 external. While the latch is held, cause_o does not change. cause_o returns to zero on a successful re-arm.
- R8: After reset the enables are 4'b1001 (parity and lockup on), the idle level is all zeros, brk_latched_o is low and cause_o is zero.
- R9: A rising edge with cfg_we_i high loads the enables from cfg_en_i and the idle level from cfg_idle_i.
- R10: With no live break and the latch clear, pwm_o equals pwm_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 4 | Alarms: 0 parity, 1 supply low, 2 clock fail, 3 lockup |
| ext_brk_i | input | 1 | External break, active high |
| cfg_we_i | input | 1 | Load enables and idle level |
| cfg_en_i | input | 4 | Per-alarm enable value |
| cfg_idle_i | input | NPWM | Safe idle level value |
| rearm_i | input | 1 | Software re-arm request |
| pwm_i | input | NPWM | Raw PWM from the timer |
| pwm_o | output | NPWM | Gated PWM to the drivers |
| brk_latched_o | output | 1 | Latched break state |
| cause_o | output | 5 | Sources live when the break latched |

## Verification
A latch that fails to set, or that clears too early, shows on pwm_o in the first cycle after the alarm drops: the raw PWM reappears instead of the idle level. A cause register that is overwritten shows as a changed cause_o at the edge of a second alarm. A wrong enable or idle register shows on pwm_o at once, in the first cycle with a live alarm. Random alarms combined with re-arm requests taken from those same cycles cover the blocked re-arm and the race where a new alarm arrives while the latch is clearing.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int unsigned NSRC     = 4;
  localparam int unsigned NCAUSE   = NSRC + 1;
  localparam int unsigned SRC_PAR  = 0;
  localparam int unsigned SRC_VDD  = 1;
  localparam int unsigned SRC_CLK  = 2;
  localparam int unsigned SRC_LOCK = 3;
  localparam int unsigned SRC_EXT  = NSRC;
  localparam logic [NSRC-1:0] EN_RST = NSRC'((1 << SRC_PAR) | (1 << SRC_LOCK));
endpackage

// File: rtl/fbu_cfg.sv
module fbu_cfg
  import fbu_pkg::*;
#(
  parameter int unsigned NPWM = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NSRC-1:0] en_d_i,
  input  logic [NPWM-1:0] idle_d_i,
  output logic [NSRC-1:0] en_q_o,
  output logic [NPWM-1:0] idle_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o   <= EN_RST;
      idle_q_o <= '0;
    end else if (we_i) begin
      en_q_o   <= en_d_i;
      idle_q_o <= idle_d_i;
    end
  end
endmodule

// File: rtl/fbu_merge.sv
module fbu_merge
  import fbu_pkg::*;
(
  input  logic              [NSRC-1:0]   fault_i,
  input  logic              [NSRC-1:0]   en_i,
  input  logic                           ext_i,
  output logic              [NCAUSE-1:0] live_src_o,
  output logic                           live_o
);
  always_comb begin
    live_src_o                  = '0;
    live_src_o[NSRC-1:0]        = fault_i & en_i;
    live_src_o[SRC_EXT]         = ext_i;
    live_o                      = |live_src_o;
  end
endmodule

// File: rtl/fbu_latch.sv
module fbu_latch
  import fbu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCAUSE-1:0] live_src_i,
  input  logic              live_i,
  input  logic              rearm_i,
  output logic              latched_o,
  output logic [NCAUSE-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_o <= 1'b0;
      cause_o   <= '0;
    end else if (!latched_o) begin
      if (live_i) begin
        latched_o <= 1'b1;
        cause_o   <= live_src_i;  // first-fault snapshot
      end
    end else if (rearm_i && !live_i) begin
      latched_o <= 1'b0;
      cause_o   <= '0;
    end
  end
endmodule

// File: rtl/fbu_gate.sv
module fbu_gate #(
  parameter int unsigned NPWM = 6
) (
  input  logic [NPWM-1:0] pwm_i,
  input  logic [NPWM-1:0] idle_i,
  input  logic            force_i,
  output logic [NPWM-1:0] pwm_o
);
  for (genvar g = 0; g < NPWM; g++) begin : g_ch
    assign pwm_o[g] = force_i ? idle_i[g] : pwm_i[g];
  end
endmodule

// File: rtl/fault_break_unit.sv
module fault_break_unit
  import fbu_pkg::*;
#(
  parameter int unsigned NPWM = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   fault_i,
  input  logic              ext_brk_i,
  input  logic              cfg_we_i,
  input  logic [NSRC-1:0]   cfg_en_i,
  input  logic [NPWM-1:0]   cfg_idle_i,
  input  logic              rearm_i,
  input  logic [NPWM-1:0]   pwm_i,
  output logic [NPWM-1:0]   pwm_o,
  output logic              brk_latched_o,
  output logic [NCAUSE-1:0] cause_o
);
  logic [NSRC-1:0]   en_q;
  logic [NPWM-1:0]   idle_q;
  logic [NCAUSE-1:0] live_src;
  logic              live;
  logic              force_idle;

  fbu_cfg #(.NPWM(NPWM)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .en_d_i(cfg_en_i), .idle_d_i(cfg_idle_i),
    .en_q_o(en_q), .idle_q_o(idle_q)
  );

  fbu_merge u_merge (
    .fault_i(fault_i), .en_i(en_q), .ext_i(ext_brk_i),
    .live_src_o(live_src), .live_o(live)
  );

  fbu_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .live_src_i(live_src), .live_i(live),
    .rearm_i(rearm_i), .latched_o(brk_latched_o), .cause_o(cause_o)
  );

  // no clock in the shutdown path
  assign force_idle = live | brk_latched_o;

  fbu_gate #(.NPWM(NPWM)) u_gate (
    .pwm_i(pwm_i), .idle_i(idle_q), .force_i(force_idle), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/fault_break_unit_chk.sv
module fault_break_unit_chk
  import fbu_pkg::*;
#(
  parameter int unsigned NPWM = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   fault_i,
  input logic              ext_brk_i,
  input logic              rearm_i,
  input logic [NPWM-1:0]   pwm_i,
  input logic [NPWM-1:0]   pwm_o,
  input logic              brk_latched_o,
  input logic [NCAUSE-1:0] cause_o,
  input logic [NSRC-1:0]   en_q,
  input logic [NPWM-1:0]   idle_q
);
  logic live_c;
  assign live_c = ext_brk_i | (|(fault_i & en_q));

  p_ext_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_brk_i |-> pwm_o == idle_q);
  p_latched_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_latched_o |-> pwm_o == idle_q);
  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_c |=> brk_latched_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_latched_o && !rearm_i) |=> brk_latched_o);
  p_rearm_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_i && live_c) |=> brk_latched_o);
  p_rearm_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_latched_o && rearm_i && !live_c) |=> !brk_latched_o && cause_o == '0);
  p_cause_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_latched_o && !rearm_i) |=> $stable(cause_o));
  p_cause_nz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_latched_o) |-> cause_o != '0);
  p_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!live_c && !brk_latched_o) |-> pwm_o == pwm_i);
endmodule

bind fault_break_unit fault_break_unit_chk #(.NPWM(NPWM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .ext_brk_i(ext_brk_i),
  .rearm_i(rearm_i), .pwm_i(pwm_i), .pwm_o(pwm_o),
  .brk_latched_o(brk_latched_o), .cause_o(cause_o),
  .en_q(en_q), .idle_q(idle_q)
);

// File: tb/fault_break_unit_bench.sv
module fault_break_unit_bench;
  localparam int NPWM = 6;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] fault_i = '0;
  logic ext_brk_i = 1'b0, cfg_we_i = 1'b0, rearm_i = 1'b0;
  logic [3:0] cfg_en_i = '0;
  logic [NPWM-1:0] cfg_idle_i = '0, pwm_i = '0, pwm_o;
  logic brk_latched_o;
  logic [4:0] cause_o;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_en;
  logic [NPWM-1:0] m_idle;
  logic m_lat;
  logic [4:0] m_cause;

  always #2.5 clk = ~clk;

  fault_break_unit #(.NPWM(NPWM)) u_fault_break_unit (
    .clk_i(clk), .rst_ni(rst_ni), .fault_i(fault_i), .ext_brk_i(ext_brk_i),
    .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_idle_i(cfg_idle_i),
    .rearm_i(rearm_i), .pwm_i(pwm_i), .pwm_o(pwm_o),
    .brk_latched_o(brk_latched_o), .cause_o(cause_o)
  );

  function automatic logic [4:0] live_src();
    return {ext_brk_i, fault_i & m_en};
  endfunction

  function automatic logic [NPWM-1:0] exp_pwm();
    return ((|live_src()) || m_lat) ? m_idle : pwm_i;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // check outputs mid-cycle, then advance one edge and update the model
  task automatic step();
    logic [4:0] ls;
    string rp;
    #1;
    ls = live_src();
    if (|ls) rp = ext_brk_i ? "R2" : "R1";
    else if (m_lat) rp = "R4";
    else rp = "R10";
    chk(rp, 32'(pwm_o), 32'(exp_pwm()));
    chk("R5", 32'(brk_latched_o), 32'(m_lat));
    chk("R7", 32'(cause_o), 32'(m_cause));
    @(posedge clk);
    if (!m_lat) begin
      if (|ls) begin m_lat = 1'b1; m_cause = ls; end
    end else if (rearm_i && !(|ls)) begin
      m_lat = 1'b0; m_cause = '0;
    end
    if (cfg_we_i) begin m_en = cfg_en_i; m_idle = cfg_idle_i; end
    @(negedge clk);
  endtask

  task automatic idle_in();
    fault_i = '0; ext_brk_i = 0; rearm_i = 0; cfg_we_i = 0;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = 4'b1001; m_idle = '0; m_lat = 0; m_cause = '0;
    #1;
    pwm_i = 6'h2d;
    #1;
    // R8 reset state
    chk("R8", 32'(brk_latched_o), 0);
    chk("R8", 32'(cause_o), 0);
    chk("R8", 32'(pwm_o), 32'h2d);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 default enables: supply low and clock fail disabled (R3)
    fault_i = 4'b0110; pwm_i = 6'h3f;
    step();
    chk("R3", 32'(brk_latched_o), 0);
    chk("R3", 32'(pwm_o), 32'h3f);
    // R1 parity source enabled by default
    fault_i = 4'b0001; step();
    chk("R5", 32'(brk_latched_o), 1);
    chk("R7", 32'(cause_o), 32'h01);
    // R7 second fault does not overwrite cause
    fault_i = 4'b1000; ext_brk_i = 1; step();
    chk("R7", 32'(cause_o), 32'h01);
    // R6 rearm with live fault blocked
    rearm_i = 1; step();
    chk("R6", 32'(brk_latched_o), 1);
    // R6 rearm succeeds
    idle_in(); rearm_i = 1; step();
    chk("R6", 32'(brk_latched_o), 0);
    chk("R6", 32'(cause_o), 0);
    // R9 enable all with idle pattern
    idle_in(); cfg_we_i = 1; cfg_en_i = 4'b1111; cfg_idle_i = 6'h15; step();
    idle_in(); fault_i = 4'b0100; pwm_i = 6'h2a; step();
    chk("R9", 32'(cause_o), 32'h04);
    chk("R9", 32'(pwm_o), 32'h15);
    idle_in(); rearm_i = 1; step();
    idle_in(); step();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      pwm_i = NPWM'($urandom);
      for (int b = 0; b < 4; b++) fault_i[b] = ($urandom % 8) == 0;
      ext_brk_i = ($urandom % 16) == 0;
      rearm_i = ($urandom % 4) == 0;
      cfg_we_i = ($urandom % 32) == 0;
      cfg_en_i = 4'($urandom);
      cfg_idle_i = NPWM'($urandom);
      step();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule